// File: doc/BRIEF.md
# Counted-Burst Emulation Clock Controller

This block produces the fastest clock of a design running inside an emulator. The clock is not free-running. A controlling processor writes a cycle count and then a start command. The block issues exactly that many clock pulses, each derived from a free-running platform clock. It then parks the clock low and flags completion. While the clock is parked, the processor can change the device inputs and step the slower clocks through ordinary registers. Those slower clocks are integer submultiples of the fast one and are driven as plain data bits, not by this block. A count of one gives single-step execution.

Each fast-clock period spans two platform cycles: one cycle high, then one cycle low. The clock comes straight from a flop, so a pulse can never be shortened or glitched at the start or end of a burst. A clock-enable output marks the platform cycle at whose closing edge the fast clock rises, for designs that prefer enables to a derived clock. A halt input, synchronised on entry, cuts a burst short at the next period boundary. The block then records how many pulses were actually applied.

The register interface is word-based, with 32-bit data. The registers are COUNT at address 0, CONTROL at address 1, STATUS at address 2, REMAIN at address 3 and APPLIED at address 4.

Top module: `emu_burst_clkctl`

## Requirements
- R1: After reset, fast_clk and fast_ce are 0. The STATUS, REMAIN, APPLIED and COUNT registers all read 0.
- R2: A start with COUNT = N > 0 is a write to address 1 with bit 0 set. The start is written in the cycle before edge E. The block then yields exactly N fast_clk pulses. fast_clk is high after edges E+1, E+3, …, E+2N-1 and low after all the edges in between.
- R3: fast_clk stays low whenever no burst is running.
- R4: The STATUS register holds busy in bit 0, done in bit 1, error in bit 2 and halted in bit 3. done becomes 1 at the same edge where the last pulse falls, and busy becomes 0 at that edge. An accepted start with a non-zero count clears done and halted.
- R5: A start with COUNT = 0 yields no pulse. It sets done at the next edge and leaves busy at 0.
- R6: A start written while busy is ignored, so the pulse total is unchanged. It sets the sticky error bit. A write to address 1 with bit 1 set clears the error bit, unless an ignored start occurs in the same cycle.
- R7: REMAIN loads the count at an accepted start and falls by one at each falling edge of fast_clk. COUNT reads back the last value written to it. A write to COUNT during a burst only affects later bursts.
- R8: A high on stop_req passes through STOP_SYNC synchroniser stages. While busy, it ends the burst at the next boundary where fast_clk is low and the edge would otherwise raise fast_clk. At that point done and halted are set and busy is cleared. APPLIED equals the number of pulses issued. A stop seen during the final high phase lets the burst complete normally, with halted at 0. A stop seen while idle has no effect.
- R9: fast_ce is high exactly in the platform cycles whose closing edge raises fast_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running platform clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| stop_req | input | 1 | Asynchronous halt request |
| fast_clk | output | 1 | Gated fast clock for the emulated design |
| fast_ce | output | 1 | Clock enable, marks the cycle before each rising edge |

## Verification
Two events can fall in the same cycle: a synchronised halt and the final falling edge of a burst. The bench provokes this by timing stop_req so that it becomes visible exactly during the last high phase. It then judges that the burst completes with every pulse and with halted at 0. A second collision is a start written while a burst is still running. The bench checks that the pulse total stays unchanged and that the error bit is set. A cycle-by-cycle model in the bench predicts fast_clk, fast_ce and every register value, and each prediction is compared on every clock.

// File: rtl/emu_clk_pkg.sv
package emu_clk_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t ADR_COUNT   = 3'd0;
  localparam reg_addr_t ADR_CTRL    = 3'd1;
  localparam reg_addr_t ADR_STATUS  = 3'd2;
  localparam reg_addr_t ADR_REMAIN  = 3'd3;
  localparam reg_addr_t ADR_APPLIED = 3'd4;

  localparam int CTRL_GO  = 0;
  localparam int CTRL_CLR = 1;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

  typedef struct packed {
    logic halted;
    logic err;
    logic done;
    logic busy;
  } stat_t;

  function automatic logic [DATA_W-1:0] pack_status(input stat_t s);
    pack_status = {{(DATA_W-4){1'b0}}, s};
  endfunction

  function automatic logic is_final(input logic [DATA_W-1:0] left);
    is_final = (left == {{(DATA_W-1){1'b0}}, 1'b1});
  endfunction

  function automatic logic [DATA_W-1:0] step_down(input logic [DATA_W-1:0] v);
    step_down = v - {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DATA_W-1:0] step_up(input logic [DATA_W-1:0] v);
    step_up = v + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/emu_clk_stop_sync.sv
module emu_clk_stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic sync_out
);
  generate
    if (STAGES == 0) begin : g_pass
      assign sync_out = raw_in;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], raw_in};
      end
      assign sync_out = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/emu_clk_regs.sv
module emu_clk_regs
  import emu_clk_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_addr_t         wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  reg_addr_t         rd_addr,
  input  logic              start_drop,
  input  logic              busy,
  input  logic              done,
  input  logic              halted,
  input  logic [CNT_W-1:0]  remain,
  input  logic [CNT_W-1:0]  applied,
  output logic              start_req,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              err_q,
  output logic [CNT_W-1:0]  rd_data
);
  logic ctrl_wr, cnt_wr, clr_req;
  stat_t stat;

  assign ctrl_wr   = wr_en && (wr_addr == ADR_CTRL);
  assign cnt_wr    = wr_en && (wr_addr == ADR_COUNT);
  assign start_req = ctrl_wr && wr_data[CTRL_GO];
  assign clr_req   = ctrl_wr && wr_data[CTRL_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (cnt_wr) cnt_q <= wr_data;
      err_q <= start_drop | (err_q & ~clr_req);
    end
  end

  assign stat = '{halted: halted, err: err_q, done: done, busy: busy};

  always_comb begin
    case (rd_addr)
      ADR_COUNT:   rd_data = cnt_q;
      ADR_STATUS:  rd_data = pack_status(stat);
      ADR_REMAIN:  rd_data = remain;
      ADR_APPLIED: rd_data = applied;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/emu_clk_burst.sv
module emu_clk_burst
  import emu_clk_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             stop_s,
  output logic             fast_clk,
  output logic             fast_ce,
  output logic             busy,
  output logic             done,
  output logic             halted,
  output logic [CNT_W-1:0] remain,
  output logic [CNT_W-1:0] applied,
  output logic             start_take,
  output logic             start_drop,
  output logic             halt_now,
  output logic             last_fall
);
  phase_e phase_q;
  logic   fclk_q, busy_q, done_q, halted_q, pend_q;
  logic [CNT_W-1:0] remain_q, applied_q;
  logic   load_zero;

  assign load_zero  = (load_cnt == '0);
  assign start_take = start_req && !busy_q;
  assign start_drop = start_req && busy_q;
  assign halt_now   = busy_q && (phase_q == PH_LOW) && (stop_s || pend_q);
  assign fast_ce    = busy_q && (phase_q == PH_LOW) && !halt_now;
  assign last_fall  = busy_q && (phase_q == PH_HIGH) && is_final(remain_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_LOW;
      fclk_q    <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      halted_q  <= 1'b0;
      pend_q    <= 1'b0;
      remain_q  <= '0;
      applied_q <= '0;
    end else if (busy_q) begin
      if (phase_q == PH_LOW) begin
        if (halt_now) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          halted_q <= 1'b1;
          pend_q   <= 1'b0;
        end else begin
          fclk_q  <= 1'b1;
          phase_q <= PH_HIGH;
        end
      end else begin
        fclk_q    <= 1'b0;
        phase_q   <= PH_LOW;
        remain_q  <= step_down(remain_q);
        applied_q <= step_up(applied_q);
        if (last_fall) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pend_q <= 1'b0;
        end else if (stop_s) begin
          pend_q <= 1'b1;
        end
      end
    end else if (start_take) begin
      remain_q  <= load_cnt;
      applied_q <= '0;
      halted_q  <= 1'b0;
      pend_q    <= 1'b0;
      phase_q   <= PH_LOW;
      if (load_zero) begin
        done_q <= 1'b1;
      end else begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end
    end
  end

  assign fast_clk = fclk_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign halted   = halted_q;
  assign remain   = remain_q;
  assign applied  = applied_q;
endmodule

// File: rtl/emu_burst_clkctl.sv
module emu_burst_clkctl
  import emu_clk_pkg::*;
#(
  parameter int STOP_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stop_req,
  output logic              fast_clk,
  output logic              fast_ce
);
  localparam int CNT_W = DATA_W;

  logic             stop_s, start_req, start_take, start_drop;
  logic             halt_now, last_fall, busy, done, halted, err_q;
  logic [CNT_W-1:0] cnt_q, remain, applied;

  emu_clk_stop_sync #(.STAGES(STOP_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(stop_req), .sync_out(stop_s)
  );

  emu_clk_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .start_drop(start_drop),
    .busy(busy), .done(done), .halted(halted), .remain(remain),
    .applied(applied), .start_req(start_req), .cnt_q(cnt_q),
    .err_q(err_q), .rd_data(rd_data)
  );

  emu_clk_burst #(.CNT_W(CNT_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .load_cnt(cnt_q),
    .stop_s(stop_s), .fast_clk(fast_clk), .fast_ce(fast_ce), .busy(busy),
    .done(done), .halted(halted), .remain(remain), .applied(applied),
    .start_take(start_take), .start_drop(start_drop),
    .halt_now(halt_now), .last_fall(last_fall)
  );
endmodule

// File: rtl/emu_burst_chk.sv
module emu_burst_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fast_clk,
  input logic        fast_ce,
  input logic        busy,
  input logic        done,
  input logic        halted,
  input logic        err_q,
  input logic        start_take,
  input logic        start_drop,
  input logic        halt_now,
  input logic [31:0] cnt_q,
  input logic [31:0] remain
);
  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clk |=> !fast_clk);

  assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fast_clk);

  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && cnt_q != 32'd0) |=> (busy && !done && !halted));

  assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && cnt_q == 32'd0) |=> (!busy && done && !fast_clk));

  assert_drop_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |=> err_q);

  assert_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_clk) |-> (remain == $past(remain) - 32'd1));

  assert_halt_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_now |=> (!busy && done && halted && !fast_clk));

  assert_enable_leads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fast_ce |=> fast_clk);
endmodule

bind emu_burst_clkctl emu_burst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fast_clk(fast_clk), .fast_ce(fast_ce),
  .busy(busy), .done(done), .halted(halted), .err_q(err_q),
  .start_take(start_take), .start_drop(start_drop), .halt_now(halt_now),
  .cnt_q(cnt_q), .remain(remain)
);

// File: tb/sim_emu_burst_clkctl.sv
`timescale 1ns/1ps
module sim_emu_burst_clkctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [2:0]  rd_addr = 3'd0;
  logic [31:0] rd_data;
  logic        stop_req = 1'b0;
  logic        fast_clk, fast_ce;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit prev_f = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  bit          m_busy, m_phase, m_done, m_err, m_halt, m_pend, m_fclk, sq0, sq1;
  logic [31:0] m_cnt, m_remain, m_applied;

  always #2 clk = ~clk;

  emu_burst_clkctl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .stop_req(stop_req), .fast_clk(fast_clk), .fast_ce(fast_ce)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit go, clr;
    if (!rst_n) begin
      m_busy = 0; m_phase = 0; m_done = 0; m_err = 0; m_halt = 0;
      m_pend = 0; m_fclk = 0; sq0 = 0; sq1 = 0;
      m_cnt = 0; m_remain = 0; m_applied = 0;
    end else begin
      go  = wr_en && wr_addr == 3'd1 && wr_data[0];
      clr = wr_en && wr_addr == 3'd1 && wr_data[1];
      m_err = (go && m_busy) || (m_err && !clr);
      if (m_busy) begin
        if (!m_phase) begin
          if (sq1 || m_pend) begin
            m_busy = 0; m_done = 1; m_halt = 1; m_pend = 0;
          end else begin
            m_fclk = 1; m_phase = 1;
          end
        end else begin
          m_fclk = 0; m_phase = 0;
          m_applied = m_applied + 1;
          if (m_remain == 1) begin
            m_busy = 0; m_done = 1; m_pend = 0;
          end else if (sq1) m_pend = 1;
          m_remain = m_remain - 1;
        end
      end else if (go) begin
        m_remain = m_cnt; m_applied = 0; m_halt = 0; m_pend = 0; m_phase = 0;
        if (m_cnt == 0) m_done = 1;
        else begin m_busy = 1; m_done = 0; end
      end
      if (wr_en && wr_addr == 3'd0) m_cnt = wr_data;
      sq1 = sq0;
      sq0 = stop_req;
    end
  end

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: exp_read = m_cnt;
      3'd2: exp_read = {28'd0, m_halt, m_err, m_done, m_busy};
      3'd3: exp_read = m_remain;
      3'd4: exp_read = m_applied;
      default: exp_read = 32'd0;
    endcase
  endfunction

  // per-cycle comparison, read address rotates
  always @(negedge clk) begin
    rd_addr = (rd_addr == 3'd4) ? 3'd0 : rd_addr + 3'd1;
    #1;
    if (rst_n && !finished) begin
      if (fast_clk && !prev_f) pulses++;
      prev_f = fast_clk;
      check(m_busy ? "R2 fast_clk" : "R3 fast_clk idle", {31'd0, fast_clk}, {31'd0, m_fclk});
      check("R9 fast_ce", {31'd0, fast_ce},
            {31'd0, m_busy && !m_phase && !(sq1 || m_pend)});
      case (rd_addr)
        3'd2:    check("R4 status", rd_data, exp_read(rd_addr));
        3'd3:    check("R7 remain", rd_data, exp_read(rd_addr));
        3'd4:    check("R8 applied", rd_data, exp_read(rd_addr));
        default: check("R7 count/ctrl", rd_data, exp_read(rd_addr));
      endcase
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    do begin @(negedge clk); #1; end while (rd_addr != a);
    v = rd_data;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic burst(input logic [31:0] n, input string tag);
    int p0;
    p0 = pulses;
    wr(3'd0, n);
    wr(3'd1, 32'd1);
    wait_idle();
    check(tag, pulses - p0, n);
  endtask

  initial begin
    logic [31:0] v;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(3'd2, v); check("R1 status after reset", v, 32'd0);
    peek(3'd3, v); check("R1 remain after reset", v, 32'd0);
    peek(3'd4, v); check("R1 applied after reset", v, 32'd0);
    peek(3'd0, v); check("R1 count after reset", v, 32'd0);
    check("R1 fast_clk after reset", {31'd0, fast_clk}, 32'd0);

    // R2 several lengths, R4 done
    burst(32'd5, "R2 pulses n=5");
    peek(3'd2, v); check("R4 done after burst", v, 32'h2);
    burst(32'd1, "R2 single step");
    burst(32'd37, "R2 pulses n=37");
    peek(3'd4, v); check("R8 applied full burst", v, 32'd37);

    // R5 zero count
    p0 = pulses;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd1);
    wait_idle();
    check("R5 zero-count pulses", pulses - p0, 0);
    peek(3'd2, v); check("R5 zero-count status", v, 32'h2);

    // R6 start while busy, R7 count write during burst
    p0 = pulses;
    wr(3'd0, 32'd6);
    wr(3'd1, 32'd1);
    repeat (3) @(negedge clk);
    wr(3'd0, 32'd9);
    wr(3'd1, 32'd1);
    wait_idle();
    check("R6 ignored start pulse total", pulses - p0, 6);
    peek(3'd2, v); check("R6 error sticky", v, 32'h6);
    wr(3'd1, 32'd2);
    peek(3'd2, v); check("R6 error cleared", v, 32'h2);
    burst(32'd9, "R7 new count used next burst");

    // R8 early stop
    p0 = pulses;
    wr(3'd0, 32'd20);
    wr(3'd1, 32'd1);
    repeat (7) @(negedge clk);
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    wait_idle();
    peek(3'd2, v); check("R8 halted status", v, 32'hA);
    peek(3'd4, v); check("R8 applied equals pulses", v, pulses - p0);
    check("R8 burst shortened", {31'd0, (pulses - p0) < 20}, 32'd1);

    // R8 stop seen during final high phase: completes normally
    p0 = pulses;
    wr(3'd0, 32'd3);
    wr(3'd1, 32'd1);
    repeat (3) @(negedge clk);
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    wait_idle();
    check("R8 last-phase stop keeps all pulses", pulses - p0, 3);
    peek(3'd2, v); check("R8 last-phase stop not halted", v, 32'h2);

    // R8 stop while idle has no effect
    stop_req = 1;
    repeat (4) @(negedge clk);
    stop_req = 0;
    repeat (3) @(negedge clk);
    peek(3'd2, v); check("R8 idle stop ignored", v, 32'h2);
    burst(32'd4, "R2 burst after idle stop");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule